// File: doc/BRIEF.md
# Hardware Timer Request Coalescer

This block sits between software-facing timer logic and a remote timer engine that can only be programmed with a relative interval in whole microseconds. It accepts absolute expiry targets in timebase ticks. From each target it derives one relative command and offers it on a valid/accept handshake. It then waits for a completion report, and a completion flagged as successful arms an in-flight timer with an expected expiry stamp.

Targets are coalesced while a command is outstanding. When the remote engine is already counting, a target triggers a new command only if it pulls the expiry meaningfully earlier. The number of reprograms between expiries is capped. A watchdog marks the remote timer as failed if the expected expiry is overrun by a wide margin. Once failed, the block ignores all further targets.

Top module: `tmr_coalescer`

## Requirements
- R1: After reset `cmd_vld` and `tmr_failed` are low.
- R2: When the target is not more than MIN_US microseconds (default 500) ahead of the timebase, including a target already in the past, the command carries exactly MIN_US.
- R3: When the target is more than MIN_US microseconds ahead, the command carries the tick difference divided by TICKS_PER_US (default 4), rounded up.
- R4: A target equal to the currently stored target produces no command.
- R5: While the in-flight flag is set, a target triggers a command only if it is earlier than the expected expiry stamp, that stamp is still ahead of the timebase, and more than MIN_US microseconds' worth of ticks remain before it. Otherwise the target produces no command.
- R6: Each issued command increments an update counter. No command is issued while the counter exceeds UPD_MAX (default 2). An expiry pulse clears the counter, including in a cycle where a command completes.
- R7: While a command is being prepared, offered or awaiting completion, a new target is kept only if it is earlier than the stored target. The kept target is issued after the completion. Later targets are dropped.
- R8: A completion with `cmd_ok` high sets the expected expiry stamp to the timebase plus the programmed microseconds times TICKS_PER_US, and sets the in-flight flag.
- R9: When the in-flight flag is set and the timebase exceeds the stamp by more than STUCK_US microseconds' worth of ticks (default 10000 us), `tmr_failed` rises. It then stays high and all later targets are ignored.
- R10: Once `cmd_vld` is high, it and `cmd_us` hold steady until `cmd_rdy` accepts the command.
- R11: When a successful completion and an expiry pulse arrive in the same cycle, the in-flight flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_vld | input | 1 | New absolute target strobe |
| tgt_val | input | TB_W | Absolute target in timebase ticks |
| tb_now | input | TB_W | Free-running timebase |
| cmd_rdy | input | 1 | Remote side accepts the offered command |
| cmd_done | input | 1 | Completion pulse for the accepted command |
| cmd_ok | input | 1 | Completion was successful (valid with cmd_done) |
| expiry_pulse | input | 1 | Remote timer expiry indication |
| cmd_vld | output | 1 | Command offered |
| cmd_us | output | US_W | Relative interval in microseconds |
| tmr_failed | output | 1 | Remote timer declared broken |

## Verification
A completion and an expiry pulse can land on the same clock edge. This matters because the completion arms a new in-flight timer while the expiry would disarm it. The bench raises `cmd_done`, `cmd_ok` and `expiry_pulse` together. It then judges the outcome only at the ports. A later target past the new stamp must stay silent, which shows that the in-flight flag survived. Advancing the timebase beyond the stuck margin must raise `tmr_failed`, which the watchdog does only when in-flight is set.

// File: rtl/tmr_coalescer_pkg.sv
package tmr_coalescer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DIV   = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } coal_state_e;
endpackage

// File: rtl/coal_divider.sv
// Restoring divider by a constant, one quotient bit per cycle.
module coal_divider #(
  parameter int W   = 32,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W-1:0] DIVISOR = W'(DIV);

  logic [W-1:0]  n_q, r_q, r_sh;
  logic [CW-1:0] cnt_q;
  logic          ge;

  always_comb begin
    r_sh = {r_q[W-2:0], n_q[W-1]};
    ge   = (r_sh >= DIVISOR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      n_q   <= '0;
      r_q   <= '0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        n_q   <= num;
        r_q   <= '0;
        cnt_q <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        r_q   <= ge ? (r_sh - DIVISOR) : r_sh;
        n_q   <= {n_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = n_q;
endmodule

// File: rtl/coal_gate.sv
// Decides whether a stored target may be issued and how far away it is.
module coal_gate #(
  parameter int TB_W      = 32,
  parameter int CNT_W     = 2,
  parameter int UPD_MAX   = 2,
  parameter int MIN_TICKS = 2000,
  parameter int TPU       = 4
) (
  input  logic [TB_W-1:0]  target,
  input  logic [TB_W-1:0]  now,
  input  logic [TB_W-1:0]  stamp,
  input  logic             in_flight,
  input  logic [CNT_W-1:0] upd_cnt,
  output logic             allow,
  output logic             far,
  output logic [TB_W-1:0]  num
);
  localparam logic [TB_W-1:0] MIN_T = TB_W'(MIN_TICKS);
  localparam logic [TB_W-1:0] RND   = TB_W'(TPU - 1);

  logic remain_ok, flight_ok;

  always_comb begin
    remain_ok = (stamp > now) && ((stamp - now) > MIN_T);
    flight_ok = !in_flight || ((target < stamp) && remain_ok);
    allow     = flight_ok && (upd_cnt <= CNT_W'(UPD_MAX));
    far       = (target > now) && ((target - now) > MIN_T);
    num       = target - now + RND;
  end
endmodule

// File: rtl/coal_watchdog.sv
// Flags a timer whose expected expiry has been overrun by a wide margin.
module coal_watchdog #(
  parameter int TB_W        = 32,
  parameter int STUCK_TICKS = 40000
) (
  input  logic [TB_W-1:0] now,
  input  logic [TB_W-1:0] stamp,
  input  logic            in_flight,
  output logic            stuck
);
  localparam logic [TB_W-1:0] LIM = TB_W'(STUCK_TICKS);

  always_comb
    stuck = in_flight && (now > stamp) && ((now - stamp) > LIM);
endmodule

// File: rtl/tmr_coalescer.sv
module tmr_coalescer
  import tmr_coalescer_pkg::*;
#(
  parameter int TB_W         = 32,
  parameter int US_W         = 20,
  parameter int TICKS_PER_US = 4,
  parameter int MIN_US       = 500,
  parameter int UPD_MAX      = 2,
  parameter int STUCK_US     = 10000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tgt_vld,
  input  logic [TB_W-1:0] tgt_val,
  input  logic [TB_W-1:0] tb_now,
  input  logic            cmd_rdy,
  input  logic            cmd_done,
  input  logic            cmd_ok,
  input  logic            expiry_pulse,
  output logic            cmd_vld,
  output logic [US_W-1:0] cmd_us,
  output logic            tmr_failed
);
  localparam int MIN_TICKS   = MIN_US * TICKS_PER_US;
  localparam int STUCK_TICKS = STUCK_US * TICKS_PER_US;
  localparam int CNT_W       = $clog2(UPD_MAX + 2);

  coal_state_e      state_q;
  logic [TB_W-1:0]  target_q, stamp_q, div_num_q;
  logic             has_new_q, in_flight_q, div_start_q, failed_q, cmd_vld_q;
  logic [CNT_W-1:0] upd_cnt_q;
  logic [US_W-1:0]  cmd_us_q;

  logic             allow, far, stuck, div_busy, div_done, arm;
  logic [TB_W-1:0]  num, quo;

  coal_gate #(
    .TB_W(TB_W), .CNT_W(CNT_W), .UPD_MAX(UPD_MAX),
    .MIN_TICKS(MIN_TICKS), .TPU(TICKS_PER_US)
  ) gate_i (
    .target(target_q), .now(tb_now), .stamp(stamp_q),
    .in_flight(in_flight_q), .upd_cnt(upd_cnt_q),
    .allow(allow), .far(far), .num(num)
  );

  coal_divider #(.W(TB_W), .DIV(TICKS_PER_US)) div_i (
    .clk(clk), .rst(rst), .start(div_start_q), .num(div_num_q),
    .busy(div_busy), .done(div_done), .quo(quo)
  );

  coal_watchdog #(.TB_W(TB_W), .STUCK_TICKS(STUCK_TICKS)) wd_i (
    .now(tb_now), .stamp(stamp_q), .in_flight(in_flight_q), .stuck(stuck)
  );

  assign arm = (state_q == ST_WAIT) && cmd_done && cmd_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      target_q    <= '0;
      stamp_q     <= '1;
      div_num_q   <= '0;
      has_new_q   <= 1'b0;
      in_flight_q <= 1'b0;
      div_start_q <= 1'b0;
      failed_q    <= 1'b0;
      cmd_vld_q   <= 1'b0;
      cmd_us_q    <= '0;
      upd_cnt_q   <= '0;
    end else begin
      div_start_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (has_new_q) begin
          has_new_q <= 1'b0;
          if (allow && !failed_q) begin
            upd_cnt_q <= upd_cnt_q + 1'b1;
            if (far) begin
              div_num_q   <= num;
              div_start_q <= 1'b1;
              state_q     <= ST_DIV;
            end else begin
              cmd_us_q  <= US_W'(MIN_US);
              cmd_vld_q <= 1'b1;
              state_q   <= ST_ISSUE;
            end
          end
        end
        ST_DIV: if (div_done && !div_busy) begin
          cmd_us_q  <= quo[US_W-1:0];
          cmd_vld_q <= 1'b1;
          state_q   <= ST_ISSUE;
        end
        ST_ISSUE: if (cmd_rdy) begin
          cmd_vld_q <= 1'b0;
          state_q   <= ST_WAIT;
        end
        ST_WAIT: if (cmd_done) begin
          if (cmd_ok) begin
            stamp_q     <= tb_now + TB_W'(cmd_us_q) * TB_W'(TICKS_PER_US);
            in_flight_q <= 1'b1;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase

      if (expiry_pulse) begin
        upd_cnt_q <= '0;
        if (!arm) in_flight_q <= 1'b0;
      end

      if (tgt_vld && !failed_q && (tgt_val != target_q)) begin
        if ((state_q != ST_IDLE) || has_new_q) begin
          if (tgt_val < target_q) begin
            target_q  <= tgt_val;
            has_new_q <= 1'b1;
          end
        end else begin
          target_q  <= tgt_val;
          has_new_q <= 1'b1;
        end
      end

      if (stuck) begin
        failed_q    <= 1'b1;
        in_flight_q <= 1'b0;
      end
    end
  end

  assign cmd_vld    = cmd_vld_q;
  assign cmd_us     = cmd_us_q;
  assign tmr_failed = failed_q;
endmodule

// File: rtl/tmr_coalescer_chk.sv
module tmr_coalescer_chk #(
  parameter int US_W   = 20,
  parameter int MIN_US = 500
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_vld,
  input logic            cmd_rdy,
  input logic [US_W-1:0] cmd_us,
  input logic            tmr_failed,
  input logic            in_flight
);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && !cmd_rdy) |=> (cmd_vld && $stable(cmd_us)));

  p_min_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |-> (cmd_us >= US_W'(MIN_US)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    tmr_failed |=> tmr_failed);

  p_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(tmr_failed) |-> $past(in_flight));

  p_disarm_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(tmr_failed) |-> !in_flight);
endmodule

bind tmr_coalescer tmr_coalescer_chk #(.US_W(US_W), .MIN_US(MIN_US)) chk_i (
  .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_rdy(cmd_rdy),
  .cmd_us(cmd_us), .tmr_failed(tmr_failed), .in_flight(in_flight_q)
);

// File: tb/tmr_coalescer_tb_top.sv
`timescale 1ns/1ps
module tmr_coalescer_tb_top;
  localparam int TB_W = 32;
  localparam int US_W = 20;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tgt_vld = 1'b0;
  logic [TB_W-1:0] tgt_val = '0;
  logic [TB_W-1:0] tb_now = '0;
  logic            cmd_rdy = 1'b0;
  logic            cmd_done = 1'b0;
  logic            cmd_ok = 1'b0;
  logic            expiry_pulse = 1'b0;
  logic            cmd_vld;
  logic [US_W-1:0] cmd_us;
  logic            tmr_failed;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tmr_coalescer dut_i (
    .clk(clk), .rst(rst), .tgt_vld(tgt_vld), .tgt_val(tgt_val),
    .tb_now(tb_now), .cmd_rdy(cmd_rdy), .cmd_done(cmd_done),
    .cmd_ok(cmd_ok), .expiry_pulse(expiry_pulse),
    .cmd_vld(cmd_vld), .cmd_us(cmd_us), .tmr_failed(tmr_failed)
  );

  typedef struct packed {
    logic [31:0] now;
    logic [31:0] tgt;
    logic [31:0] us;
  } vec_t;

  // R2 cases: 0, 4, 6, 7; R3 cases: 1, 2, 3, 5
  localparam vec_t VEC [8] = '{
    '{32'd1000, 32'd3000,  32'd500},
    '{32'd1000, 32'd3001,  32'd501},
    '{32'd1000, 32'd3004,  32'd501},
    '{32'd1000, 32'd3005,  32'd502},
    '{32'd5000, 32'd4000,  32'd500},
    '{32'd5000, 32'd45000, 32'd10000},
    '{32'd5000, 32'd5001,  32'd500},
    '{32'd0,    32'd7,     32'd500}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_tgt(input logic [TB_W-1:0] t);
    tgt_vld = 1'b1;
    tgt_val = t;
    @(negedge clk);
    tgt_vld = 1'b0;
  endtask

  // Waits for a command, checks its value and that it holds, then accepts it.
  task automatic expect_cmd(input logic [US_W-1:0] us, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 80 && !seen; i++) begin
      @(negedge clk);
      seen = cmd_vld;
    end
    check(seen, req, longint'(seen), 1);
    if (seen) begin
      check(cmd_us == us, req, longint'(cmd_us), longint'(us));
      @(negedge clk);
      check(cmd_vld && cmd_us == us, "R10 hold", longint'(cmd_us), longint'(us));
      cmd_rdy = 1'b1;
      @(negedge clk);
      cmd_rdy = 1'b0;
    end
  endtask

  task automatic complete(input bit ok);
    cmd_done = 1'b1;
    cmd_ok   = ok;
    @(negedge clk);
    cmd_done = 1'b0;
    cmd_ok   = 1'b0;
  endtask

  task automatic pulse_exp();
    expiry_pulse = 1'b1;
    @(negedge clk);
    expiry_pulse = 1'b0;
  endtask

  task automatic expect_quiet(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cmd_vld) seen = 1'b1;
    end
    check(!seen, req, longint'(seen), 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!cmd_vld, "R1 cmd_vld", longint'(cmd_vld), 0);
    check(!tmr_failed, "R1 tmr_failed", longint'(tmr_failed), 0);

    // R2 and R3 interval table
    foreach (VEC[i]) begin
      tb_now = VEC[i].now;
      send_tgt(VEC[i].tgt);
      expect_cmd(US_W'(VEC[i].us), "R2 or R3 interval");
      complete(1'b0);
      pulse_exp();
    end

    // R4: equal target ignored
    send_tgt(32'd7);
    expect_quiet("R4 equal target");

    // R6: update limit and clearing by expiry
    tb_now = 32'd0;
    send_tgt(32'd100); expect_cmd(20'd500, "R6 first");  complete(1'b0);
    send_tgt(32'd200); expect_cmd(20'd500, "R6 second"); complete(1'b0);
    send_tgt(32'd300); expect_cmd(20'd500, "R6 third");  complete(1'b0);
    send_tgt(32'd400); expect_quiet("R6 limit");
    pulse_exp();
    send_tgt(32'd500); expect_cmd(20'd500, "R6 after expiry"); complete(1'b0);
    pulse_exp();

    // R5 and R8: in-flight gating against the stamp 1000 + 5000*4 = 21000
    tb_now = 32'd1000;
    send_tgt(32'd21000); expect_cmd(20'd5000, "R3 long"); complete(1'b1);
    send_tgt(32'd30000); expect_quiet("R5 later than stamp");
    tb_now = 32'd19000;
    send_tgt(32'd20000); expect_quiet("R5 R8 remaining equals minimum");
    tb_now = 32'd18999;
    send_tgt(32'd19500); expect_cmd(20'd500, "R5 R8 remaining above minimum");
    complete(1'b0);
    pulse_exp();

    // R7: coalescing while a command awaits completion
    tb_now = 32'd100000;
    send_tgt(32'd108000); expect_cmd(20'd2000, "R7 first");
    send_tgt(32'd200000);
    send_tgt(32'd104000);
    complete(1'b0);
    expect_cmd(20'd1000, "R7 earlier kept");
    complete(1'b0);
    expect_quiet("R7 later dropped");
    pulse_exp();

    // R11: completion and expiry in the same cycle; stamp 300000 + 4000
    tb_now = 32'd300000;
    send_tgt(32'd304000); expect_cmd(20'd1000, "R11 setup");
    cmd_done = 1'b1; cmd_ok = 1'b1; expiry_pulse = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0; cmd_ok = 1'b0; expiry_pulse = 1'b0;
    send_tgt(32'd400000); expect_quiet("R11 in-flight kept");

    // R9: watchdog boundary, then failure
    tb_now = 32'd344000;
    repeat (3) @(negedge clk);
    check(!tmr_failed, "R9 at margin", longint'(tmr_failed), 0);
    tb_now = 32'd344001;
    repeat (2) @(negedge clk);
    check(tmr_failed, "R9 past margin", longint'(tmr_failed), 1);
    tb_now = 32'd0;
    send_tgt(32'd1); expect_quiet("R9 ignored after failure");
    check(tmr_failed, "R9 sticky", longint'(tmr_failed), 1);

    finish_run();
  end
endmodule